// File: doc/BRIEF.md
# DAC Serial Command Register Interface

This block is the device side of a serial link for a single-channel voltage-output DAC. A host sends 24-bit command frames over a four-wire SPI bus, most significant bit first. The block decodes a 4-bit command code in each frame and updates two registers: the DAC code and a small control register. The control register holds an output-range select, an internal-reference enable and a thermal-shutdown enable flag. Both registers drive parallel outputs towards the analog core.

The SPI pins are brought into the block's system clock through two-flop synchronizers. Data is taken on the falling SCLK edge and launched on the rising edge, so the block works with a clock that idles low (SPI mode 1) or high (SPI mode 2), and SCLK must be slow compared with the system clock. A frame takes effect only when chip select is released after exactly 24 bits.

Reading takes two frames. A read command loads a reply word, and the host clocks that word out on MISO during its next frame, which is normally a no-op. There are two reset commands: one clears only the DAC code and the other clears both registers. The parameter `RES` selects a 16-bit or a 12-bit DAC code. The 12-bit code sits in the upper bits of the 16-bit payload.

Top module: `dac_spi_cmd_if`

## Requirements
- R1: A frame is 24 bits, MSB first. Frame bits 19:16 are the command code and bits 15:0 the payload. Bits 23:20 are ignored.
- R2: Command 0x3 loads the DAC code from the payload's upper `RES` bits, and `dac_code` shows the new value.
- R3: Command 0x4 loads the control register: payload bits 2:0 go to `range_sel`, bit 5 to `int_ref_en` and bit 6 to `ets_flag`. Other payload bits are not stored and read back as zero.
- R4: Command 0x7 clears the DAC code to zero and leaves the control register unchanged.
- R5: Command 0xF clears both the DAC code and the control register.
- R6: Read commands are 0xB (DAC code) and 0xC (control). They load a reply with bits 23:20 zero, the command code in bits 19:16 and the register image in bits 15:0. The DAC image is left-justified and the control image uses the R3 bit positions. The reply is shifted out MSB first during the next frame. Every other frame, including a discarded one, leaves a reply of zero.
- R7: A frame takes effect only on the release of `cs_n` after exactly 24 SCLK falling edges. Shorter or longer frames change no register.
- R8: MOSI is sampled on falling SCLK edges and MISO advances on rising edges that follow a sample. This works both with SCLK idling low and with SCLK idling high.
- R9: `miso_oe` is high only while a frame is in progress. When it is low, `miso` is 0.
- R10: Reset clears the DAC code, the control register and any pending reply, and deasserts `miso_oe`.
- R11: With `RES`=12, payload bits 3:0 are ignored on write and read back as zero.
- R12: All other command codes, including the no-op 0x0, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial reply data, 0 when not driven |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| dac_code | output | RES | Current DAC code |
| range_sel | output | 3 | Selected output range |
| int_ref_en | output | 1 | Internal reference enable |
| ets_flag | output | 1 | Thermal-shutdown enable flag |

## Verification
Each pin passes through two synchronizer flops and one edge-detect stage before it acts. A command therefore reaches `dac_code` and the control outputs about four system clocks after `cs_n` rises, and a MISO bit settles about four clocks after its rising SCLK edge. The bench holds every SCLK phase for six clocks and reads MISO at the end of the high phase. It waits twelve clocks after releasing `cs_n` before it checks the registers. A read reply is compared bit by bit with the data captured during the following frame, in both SCLK polarities. A 12-bit instance shares the same pins, so the left-justified readback is checked against the same traffic.

// File: rtl/dac_spi_pkg.sv
package dac_spi_pkg;

    localparam int FRAME_BITS = 24;
    localparam int CMD_W      = 4;
    localparam int DATA_W     = 16;
    localparam int KEEP_BITS  = CMD_W + DATA_W;
    localparam int RANGE_W    = 3;

    // control field positions inside the 16-bit payload
    localparam int CTRL_ETS_POS  = 6;
    localparam int CTRL_IREF_POS = 5;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP      = 4'h0,
        CMD_WR_DAC   = 4'h3,
        CMD_WR_CTRL  = 4'h4,
        CMD_CLR_DATA = 4'h7,
        CMD_RD_DAC   = 4'hB,
        CMD_RD_CTRL  = 4'hC,
        CMD_CLR_ALL  = 4'hF
    } cmd_e;

    typedef struct packed {
        logic               ets;
        logic               int_ref;
        logic [RANGE_W-1:0] range_sel;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '0;

    function automatic logic is_read_cmd(input logic [CMD_W-1:0] c);
        return (c == CMD_RD_DAC) || (c == CMD_RD_CTRL);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_image(input ctrl_t c);
        logic [DATA_W-1:0] img;
        img = '0;
        img[CTRL_ETS_POS]      = c.ets;
        img[CTRL_IREF_POS]     = c.int_ref;
        img[RANGE_W-1:0]       = c.range_sel;
        return img;
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_reply(input logic [CMD_W-1:0] c,
                                                          input logic [DATA_W-1:0] v);
        return {{(FRAME_BITS-KEEP_BITS){1'b0}}, c, v};
    endfunction

endpackage

// File: rtl/dac_spi_sync.sv
module dac_spi_sync #(
    parameter int              WIDTH     = 1,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= RESET_VAL;
        else     pipe[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[s] <= RESET_VAL;
            else     pipe[s] <= pipe[s-1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/dac_spi_shift.sv
module dac_spi_shift
    import dac_spi_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_fall,
    input  logic                  cs_rise,
    input  logic                  sclk_rise,
    input  logic                  sclk_fall,
    input  logic                  mosi_bit,
    input  logic [FRAME_BITS-1:0] reply_in,
    output logic [KEEP_BITS-1:0]  rx_bits,
    output logic                  frame_end,
    output logic                  commit,
    output logic                  miso_bit,
    output logic                  drive_en
);
    localparam int                CNT_W   = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0]  CNT_TOP = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0]  CNT_OK  = CNT_W'(FRAME_BITS);

    logic                  active;
    logic [CNT_W-1:0]      bit_cnt;
    logic [KEEP_BITS-1:0]  rx_sr;
    logic [FRAME_BITS-1:0] tx_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
        end else if (cs_fall) begin
            active  <= 1'b1;
            bit_cnt <= '0;
            tx_sr   <= reply_in;
        end else if (cs_rise) begin
            active  <= 1'b0;
        end else if (active) begin
            if (sclk_fall) begin
                rx_sr <= {rx_sr[KEEP_BITS-2:0], mosi_bit};
                if (bit_cnt != CNT_TOP) bit_cnt <= bit_cnt + 1'b1;
            end
            if (sclk_rise && bit_cnt != '0) begin
                tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    assign frame_end = cs_rise & active;
    assign commit    = frame_end & (bit_cnt == CNT_OK);
    assign rx_bits   = rx_sr;
    assign miso_bit  = tx_sr[FRAME_BITS-1];
    assign drive_en  = active;
endmodule

// File: rtl/dac_spi_regs.sv
module dac_spi_regs
    import dac_spi_pkg::*;
#(
    parameter int RES = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  commit,
    input  logic                  frame_end,
    input  logic [KEEP_BITS-1:0]  frame,
    output logic [RES-1:0]        dac_q,
    output ctrl_t                 ctrl_q,
    output logic [FRAME_BITS-1:0] reply_q
);
    logic [CMD_W-1:0]  cmd;
    logic [DATA_W-1:0] payload;
    logic [DATA_W-1:0] dac_image;
    logic [DATA_W-1:0] read_val;

    assign cmd     = frame[KEEP_BITS-1 -: CMD_W];
    assign payload = frame[DATA_W-1:0];

    if (RES == DATA_W) begin : g_full
        assign dac_image = dac_q;
    end else begin : g_narrow
        assign dac_image = {dac_q, {(DATA_W-RES){1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_q  <= '0;
            ctrl_q <= CTRL_RESET;
        end else if (commit) begin
            case (cmd)
                CMD_WR_DAC:   dac_q <= payload[DATA_W-1 -: RES];
                CMD_WR_CTRL: begin
                    ctrl_q.ets       <= payload[CTRL_ETS_POS];
                    ctrl_q.int_ref   <= payload[CTRL_IREF_POS];
                    ctrl_q.range_sel <= payload[RANGE_W-1:0];
                end
                CMD_CLR_DATA: dac_q <= '0;
                CMD_CLR_ALL: begin
                    dac_q  <= '0;
                    ctrl_q <= CTRL_RESET;
                end
                default: ;
            endcase
        end
    end

    assign read_val = (cmd == CMD_RD_DAC) ? dac_image : ctrl_image(ctrl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            reply_q <= '0;
        end else if (frame_end) begin
            reply_q <= (commit && is_read_cmd(cmd)) ? build_reply(cmd, read_val) : '0;
        end
    end
endmodule

// File: rtl/dac_spi_cmd_if.sv
module dac_spi_cmd_if
    import dac_spi_pkg::*;
#(
    parameter int RES         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sclk,
    input  logic           cs_n,
    input  logic           mosi,
    output logic           miso,
    output logic           miso_oe,
    output logic [RES-1:0] dac_code,
    output logic [2:0]     range_sel,
    output logic           int_ref_en,
    output logic           ets_flag
);
    logic [2:0]            pins_s;
    logic                  cs_s, sclk_s, mosi_s;
    logic                  cs_p, sclk_p;
    logic                  cs_fall, cs_rise, sclk_rise, sclk_fall;
    logic [KEEP_BITS-1:0]  rx_bits;
    logic                  frame_end, commit, miso_bit, drive_en;
    logic [FRAME_BITS-1:0] reply_word;
    ctrl_t                 ctrl_q;

    dac_spi_sync #(
        .WIDTH    (3),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(3'b100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({cs_n, sclk, mosi}),
        .dout(pins_s)
    );

    assign {cs_s, sclk_s, mosi_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_p   <= 1'b1;
            sclk_p <= 1'b0;
        end else begin
            cs_p   <= cs_s;
            sclk_p <= sclk_s;
        end
    end

    assign cs_fall   =  cs_p   & ~cs_s;
    assign cs_rise   = ~cs_p   &  cs_s;
    assign sclk_rise = ~sclk_p &  sclk_s;
    assign sclk_fall =  sclk_p & ~sclk_s;

    dac_spi_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .mosi_bit (mosi_s),
        .reply_in (reply_word),
        .rx_bits  (rx_bits),
        .frame_end(frame_end),
        .commit   (commit),
        .miso_bit (miso_bit),
        .drive_en (drive_en)
    );

    dac_spi_regs #(.RES(RES)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .frame_end(frame_end),
        .frame    (rx_bits),
        .dac_q    (dac_code),
        .ctrl_q   (ctrl_q),
        .reply_q  (reply_word)
    );

    assign range_sel  = ctrl_q.range_sel;
    assign int_ref_en = ctrl_q.int_ref;
    assign ets_flag   = ctrl_q.ets;
    assign miso_oe    = drive_en;
    assign miso       = drive_en & miso_bit;
endmodule

// File: rtl/dac_spi_cmd_if_chk.sv
module dac_spi_cmd_if_chk #(
    parameter int RES = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           commit,
    input logic           frame_end,
    input logic [3:0]     frame_cmd,
    input logic [15:0]    frame_data,
    input logic [RES-1:0] dac_code,
    input logic [2:0]     range_sel,
    input logic           int_ref_en,
    input logic           ets_flag,
    input logic           miso_oe,
    input logic [23:0]    reply_word
);
    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (dac_code == '0 && range_sel == 3'd0 && !int_ref_en && !ets_flag
                 && !miso_oe && reply_word == 24'd0));

    assert_hold_without_commit_R7: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(dac_code) && $stable(range_sel)
                     && $stable(int_ref_en) && $stable(ets_flag)));

    assert_dac_load_R2: assert property (@(posedge clk) disable iff (rst)
        (commit && frame_cmd == 4'h3) |=> dac_code == $past(frame_data[15 -: RES]));

    assert_data_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (commit && frame_cmd == 4'h7) |=> (dac_code == '0 && $stable(range_sel)
                                           && $stable(int_ref_en) && $stable(ets_flag)));

    assert_full_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (commit && frame_cmd == 4'hF) |=> (dac_code == '0 && range_sel == 3'd0
                                           && !int_ref_en && !ets_flag));

    assert_reply_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !(commit && (frame_cmd == 4'hB || frame_cmd == 4'hC)))
            |=> reply_word == 24'd0);
endmodule

bind dac_spi_cmd_if dac_spi_cmd_if_chk #(.RES(RES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .commit    (commit),
    .frame_end (frame_end),
    .frame_cmd (rx_bits[19:16]),
    .frame_data(rx_bits[15:0]),
    .dac_code  (dac_code),
    .range_sel (range_sel),
    .int_ref_en(int_ref_en),
    .ets_flag  (ets_flag),
    .miso_oe   (miso_oe),
    .reply_word(reply_word)
);

// File: tb/dac_spi_cmd_if_test.sv
module dac_spi_cmd_if_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int SETTLE     = 12;
    localparam int NV         = 22;

    typedef struct packed {
        logic        mode2;
        logic [5:0]  nbits;
        logic [23:0] frame;
        logic [15:0] dac;
        logic [7:0]  ctrl;
        logic [23:0] rep16;
        logic [23:0] rep12;
    } vec_t;

    // ctrl column: bit6 ets, bit5 internal ref, bits 2:0 range
    localparam vec_t VECS [NV] = '{
        '{1'b0, 6'd24, 24'h031234, 16'h1234, 8'h00, 24'h000000, 24'h000000},
        '{1'b1, 6'd24, 24'h0B0000, 16'h1234, 8'h00, 24'h000000, 24'h000000},
        '{1'b0, 6'd24, 24'h000000, 16'h1234, 8'h00, 24'h0B1234, 24'h0B1230},
        '{1'b1, 6'd24, 24'h040065, 16'h1234, 8'h65, 24'h000000, 24'h000000},
        '{1'b0, 6'd24, 24'h0C0000, 16'h1234, 8'h65, 24'h000000, 24'h000000},
        '{1'b1, 6'd24, 24'h000000, 16'h1234, 8'h65, 24'h0C0065, 24'h0C0065},
        '{1'b0, 6'd24, 24'hF3ABCD, 16'hABCD, 8'h65, 24'h000000, 24'h000000},
        '{1'b1, 6'd24, 24'h04FF9A, 16'hABCD, 8'h02, 24'h000000, 24'h000000},
        '{1'b0, 6'd24, 24'h0C0000, 16'hABCD, 8'h02, 24'h000000, 24'h000000},
        '{1'b1, 6'd24, 24'h0B0000, 16'hABCD, 8'h02, 24'h0C0002, 24'h0C0002},
        '{1'b0, 6'd24, 24'h000000, 16'hABCD, 8'h02, 24'h0BABCD, 24'h0BABC0},
        '{1'b1, 6'd24, 24'h070000, 16'h0000, 8'h02, 24'h000000, 24'h000000},
        '{1'b0, 6'd24, 24'h0B0000, 16'h0000, 8'h02, 24'h000000, 24'h000000},
        '{1'b1, 6'd24, 24'h000000, 16'h0000, 8'h02, 24'h0B0000, 24'h0B0000},
        '{1'b0, 6'd20, 24'h035555, 16'h0000, 8'h02, 24'h000000, 24'h000000},
        '{1'b1, 6'd25, 24'h035555, 16'h0000, 8'h02, 24'h000000, 24'h000000},
        '{1'b0, 6'd24, 24'h01FFFF, 16'h0000, 8'h02, 24'h000000, 24'h000000},
        '{1'b1, 6'd24, 24'h035555, 16'h5555, 8'h02, 24'h000000, 24'h000000},
        '{1'b0, 6'd24, 24'h0B0000, 16'h5555, 8'h02, 24'h000000, 24'h000000},
        '{1'b1, 6'd24, 24'h0F0000, 16'h0000, 8'h00, 24'h0B5555, 24'h0B5550},
        '{1'b0, 6'd24, 24'h0C0000, 16'h0000, 8'h00, 24'h000000, 24'h000000},
        '{1'b1, 6'd24, 24'h000000, 16'h0000, 8'h00, 24'h0C0000, 24'h0C0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso, miso_oe, miso_n, miso_oe_n;
    logic [15:0] dac_code;
    logic [11:0] dac_code_n;
    logic [2:0]  range_sel, range_sel_n;
    logic        int_ref_en, ets_flag, int_ref_en_n, ets_flag_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_spi_cmd_if #(.RES(16)) uut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .dac_code(dac_code),
        .range_sel(range_sel), .int_ref_en(int_ref_en), .ets_flag(ets_flag)
    );

    dac_spi_cmd_if #(.RES(12)) uut_narrow (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso_n), .miso_oe(miso_oe_n), .dac_code(dac_code_n),
        .range_sel(range_sel_n), .int_ref_en(int_ref_en_n), .ets_flag(ets_flag_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ctrl_out16();
        return {1'b0, ets_flag, int_ref_en, 2'b00, range_sel};
    endfunction

    function automatic logic [7:0] ctrl_out12();
        return {1'b0, ets_flag_n, int_ref_en_n, 2'b00, range_sel_n};
    endfunction

    task automatic send_frame(input logic mode2, input logic [23:0] frame, input int nbits,
                              output logic [23:0] rx16, output logic [23:0] rx12);
        rx16 = '0;
        rx12 = '0;
        sclk = mode2;
        tick(2*HALF);
        cs_n = 1'b0;
        tick(HALF);
        for (int i = 0; i < nbits; i++) begin
            logic b;
            b = (i < 24) ? frame[23-i] : 1'b0;
            if (!mode2) begin
                sclk = 1'b1;
                mosi = b;
                tick(HALF);
                if (i < 24) begin
                    rx16[23-i] = miso;
                    rx12[23-i] = miso_n;
                end
                sclk = 1'b0;
                tick(HALF);
            end else begin
                mosi = b;
                tick(HALF);
                if (i < 24) begin
                    rx16[23-i] = miso;
                    rx12[23-i] = miso_n;
                end
                sclk = 1'b0;
                tick(HALF);
                sclk = 1'b1;
            end
        end
        tick(HALF);
        cs_n = 1'b1;
        tick(SETTLE);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [23:0] r16, r12;
        tick(5);
        rst = 1'b0;
        tick(3);

        // R10: state after reset
        check(dac_code == 16'h0 && dac_code_n == 12'h0, "R10", "dac after reset", 32'(dac_code), 0);
        check(ctrl_out16() == 8'h00, "R10", "ctrl after reset", 32'(ctrl_out16()), 0);
        check(miso_oe == 1'b0 && miso == 1'b0, "R10", "miso idle after reset", {miso_oe, miso}, 0);

        // R9: enable follows chip select with no clocks at all
        cs_n = 1'b0;
        tick(2*HALF);
        check(miso_oe == 1'b1 && miso_oe_n == 1'b1, "R9", "oe during frame", 32'(miso_oe), 1);
        cs_n = 1'b1;
        tick(2*HALF);
        check(miso_oe == 1'b0 && miso == 1'b0, "R9", "oe after frame", {miso_oe, miso}, 0);

        // R1..R8, R11, R12: vector table, alternating SCLK idle level (R8)
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            t = VECS[v];
            send_frame(t.mode2, t.frame, int'(t.nbits), r16, r12);
            check(dac_code == t.dac, "R1 R2 R4 R5 R7 R12", $sformatf("vec %0d dac", v),
                  32'(dac_code), 32'(t.dac));
            check(dac_code_n == t.dac[15:4], "R11", $sformatf("vec %0d narrow dac", v),
                  32'(dac_code_n), 32'(t.dac[15:4]));
            check(ctrl_out16() == t.ctrl && ctrl_out12() == t.ctrl, "R3 R5 R7",
                  $sformatf("vec %0d ctrl", v), 32'(ctrl_out16()), 32'(t.ctrl));
            if (t.nbits == 6'd24) begin
                check(r16 == t.rep16, "R6 R8", $sformatf("vec %0d reply", v),
                      32'(r16), 32'(t.rep16));
                check(r12 == t.rep12, "R6 R11", $sformatf("vec %0d narrow reply", v),
                      32'(r12), 32'(t.rep12));
            end
            check(miso_oe == 1'b0 && miso == 1'b0, "R9", $sformatf("vec %0d idle miso", v),
                  {miso_oe, miso}, 0);
        end

        // R10: reset clears registers and a pending reply
        send_frame(1'b0, 24'h037777, 24, r16, r12);
        send_frame(1'b0, 24'h040047, 24, r16, r12);
        check(dac_code == 16'h7777 && ctrl_out16() == 8'h47, "R2 R3", "pre-reset load",
              {dac_code, 8'h0, ctrl_out16()}, 32'h77770047);
        send_frame(1'b0, 24'h0B0000, 24, r16, r12);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(3);
        check(dac_code == 16'h0 && ctrl_out16() == 8'h00, "R10", "regs after mid-run reset",
              {dac_code, 8'h0, ctrl_out16()}, 0);
        send_frame(1'b1, 24'h000000, 24, r16, r12);
        check(r16 == 24'h0, "R10", "pending reply dropped by reset", 32'(r16), 0);

        done = 1'b1;
        finish_run();
    end
endmodule